// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block is the register and control core of an 8-bit digitally controlled potentiometer. It drives an 8-bit tap code to the resistor array. Code 00h selects the tap closest to the low end and FFh selects the tap closest to the high end. Codes in between step through the taps in order. The block keeps a volatile wiper register and a one-bit access selector. It also models a non-volatile bank holding a stored start-up wiper value, five general-purpose bytes and a fixed identification byte.

A byte-wide register port takes the place of a serial front end. The port has an address, write data, a write strobe and combinational read data. Address 0 is shared between the stored start-up value and the live wiper, and the access selector decides which one a transfer reaches. A write to the stored value also sets the live wiper.

After reset the wiper holds mid-scale. It waits for a memory-ready input, then copies in the stored start-up value one stage later. Until that recall is complete, the register port ignores all writes. The non-volatile model is not cleared by the reset. Only a factory-initialisation input clears it.

Top module: `dpot_regs`

## Requirements
- R1: The `wiper` output carries the wiper register. Writing code v makes `wiper` equal v, so 00h gives the low end, FFh gives the high end, and every code between is passed through unchanged.
- R2: After reset `wiper` is 80h and stays 80h until `mem_ready` is sampled high. On the second rising edge after that sample, `wiper` equals the stored start-up value.
- R3: The selector is bit 7 of address 8. When it is 1, address 0 reads and writes the live wiper only, and writes there leave the stored start-up value unchanged.
- R4: When the selector is 0, address 0 reads the stored start-up value, and addresses 2 to 6 are five read/write general-purpose bytes. When the selector is 1, addresses 1 to 6 read 00h and writes to addresses 1 to 6 are ignored.
- R5: When the selector is 0, a write to address 0 updates the stored start-up value and the live wiper on the same edge.
- R6: Reset clears the selector to 0. Factory initialisation (`nv_clear` high at a clock edge) sets the stored start-up value to 80h and the general-purpose bytes to 00h.
- R7: Address 8 reads as {selector, 7'b0}. Only bit 7 of a write there is kept.
- R8: When the selector is 0, address 1 reads the identification byte 80h. Writes to address 1 never change it.
- R9: Address 7 and addresses 9 to 15 read 00h, and writes to them change no register.
- R10: Until the recall of R2 has completed, writes to every address are ignored.
- R11: The stored start-up value and the general-purpose bytes keep their contents across a `rst_n` pulse.
- R12: `wiper` is registered. It changes on the rising edge that samples a wiper or start-up value write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nv_clear | input | 1 | Factory initialisation of the non-volatile model |
| mem_ready | input | 1 | Non-volatile contents readable; starts the recall |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| rdata | output | 8 | Read data for `addr`, combinational |
| wiper | output | 8 | Registered tap code to the resistor array |

## Verification
The checker tests several rules on every cycle:
- the mid-scale hold before recall;
- the recall copying the stored value;
- the write lockout before recall;
- the mirror from a start-up value write to the wiper;
- volatile-only writes leaving the stored value untouched;
- the fixed identification and selector read patterns.

Only the bench's scenarios can show the other behaviours. These are the exhaustive sweep of all 256 wiper codes, retention of the non-volatile bytes across a reset pulse, recall of a non-default start-up value, and the exact edge at which the output moves.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int DW     = 8;
  localparam int AW     = 4;
  localparam int NUM_GP = 5;

  localparam logic [AW-1:0] A_IVR = 4'd0;
  localparam logic [AW-1:0] A_ID  = 4'd1;
  localparam logic [AW-1:0] A_GP0 = 4'd2;
  localparam logic [AW-1:0] A_ACR = 4'd8;

  localparam logic [DW-1:0] MID_CODE = 8'h80;
  localparam logic [DW-1:0] ID_CODE  = 8'h80;

  typedef enum logic [1:0] {PU_PRESET, PU_RECALL, PU_RUN} pu_state_e;
endpackage

// File: rtl/dpot_seq.sv
module dpot_seq
  import dpot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mem_ready,
  output logic load_ivr,
  output logic run
);
  pu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PU_PRESET: if (mem_ready) state_d = PU_RECALL;
      PU_RECALL: state_d = PU_RUN;
      default:   state_d = PU_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PU_PRESET;
    else        state_q <= state_d;
  end

  assign load_ivr = (state_q == PU_RECALL);
  assign run      = (state_q == PU_RUN);
endmodule

// File: rtl/dpot_nvbank.sv
module dpot_nvbank
  import dpot_pkg::*;
#(
  parameter int W   = DW,
  parameter int NGP = NUM_GP
) (
  input  logic                    clk,
  input  logic                    nv_clear,
  input  logic                    ivr_we,
  input  logic [NGP-1:0]          gp_we,
  input  logic [W-1:0]            wdata,
  output logic [W-1:0]            ivr,
  output logic [NGP-1:0][W-1:0]   gp
);
  // Non-volatile model: no reset; only factory clear or a write changes it.
  logic          ivr_en;
  logic [W-1:0]  ivr_d;

  assign ivr_en = nv_clear | ivr_we;
  assign ivr_d  = nv_clear ? W'(MID_CODE) : wdata;

  always_ff @(posedge clk) begin
    if (ivr_en) ivr <= ivr_d;
  end

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    logic         en;
    logic [W-1:0] d;
    assign en = nv_clear | gp_we[g];
    assign d  = nv_clear ? '0 : wdata;
    always_ff @(posedge clk) begin
      if (en) gp[g] <= d;
    end
  end
endmodule

// File: rtl/dpot_decode.sv
module dpot_decode
  import dpot_pkg::*;
#(
  parameter int W   = DW,
  parameter int A   = AW,
  parameter int NGP = NUM_GP
) (
  input  logic [A-1:0]            addr,
  input  logic                    wr_en,
  input  logic                    run,
  input  logic                    vol,
  input  logic [W-1:0]            wiper,
  input  logic [W-1:0]            ivr,
  input  logic [NGP-1:0][W-1:0]   gp,
  output logic                    ivr_we,
  output logic                    wiper_we,
  output logic                    acr_we,
  output logic [NGP-1:0]          gp_we,
  output logic [W-1:0]            rdata
);
  logic           wr_ok;
  logic [NGP-1:0] gp_hit;

  assign wr_ok    = wr_en & run;
  assign ivr_we   = wr_ok & ~vol & (addr == A_IVR);
  assign wiper_we = wr_ok &  vol & (addr == A_IVR);
  assign acr_we   = wr_ok & (addr == A_ACR);

  for (genvar g = 0; g < NGP; g++) begin : g_hit
    localparam logic [A-1:0] GA = A'(int'(A_GP0) + g);
    assign gp_hit[g] = (addr == GA);
    assign gp_we[g]  = wr_ok & ~vol & gp_hit[g];
  end

  always_comb begin
    rdata = '0;
    if (addr == A_IVR)      rdata = vol ? wiper : ivr;
    else if (addr == A_ID)  rdata = vol ? '0 : W'(ID_CODE);
    else if (addr == A_ACR) rdata = {vol, {(W-1){1'b0}}};
    else if (!vol) begin
      for (int i = 0; i < NGP; i++) begin
        if (gp_hit[i]) rdata = gp[i];
      end
    end
  end
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int W   = DW,
  parameter int A   = AW,
  parameter int NGP = NUM_GP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         nv_clear,
  input  logic         mem_ready,
  input  logic [A-1:0] addr,
  input  logic [W-1:0] wdata,
  input  logic         wr_en,
  output logic [W-1:0] rdata,
  output logic [W-1:0] wiper
);
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic                  load_ivr, run;
  logic                  ivr_we, wiper_we, acr_we;
  logic [NGP-1:0]        gp_we;
  logic [W-1:0]          ivr;
  logic [NGP-1:0][W-1:0] gp;
  logic                  vol_q;
  logic [W-1:0]          wiper_q, wiper_d;
  logic                  wiper_en;

  dpot_seq u_seq (
    .clk(clk), .rst_n(rst_q_n), .mem_ready(mem_ready),
    .load_ivr(load_ivr), .run(run)
  );

  dpot_nvbank #(.W(W), .NGP(NGP)) u_nv (
    .clk(clk), .nv_clear(nv_clear), .ivr_we(ivr_we), .gp_we(gp_we),
    .wdata(wdata), .ivr(ivr), .gp(gp)
  );

  dpot_decode #(.W(W), .A(A), .NGP(NGP)) u_dec (
    .addr(addr), .wr_en(wr_en), .run(run), .vol(vol_q),
    .wiper(wiper_q), .ivr(ivr), .gp(gp),
    .ivr_we(ivr_we), .wiper_we(wiper_we), .acr_we(acr_we),
    .gp_we(gp_we), .rdata(rdata)
  );

  // Wiper next state: recall first, then either write path.
  always_comb begin
    wiper_d = wiper_q;
    if (load_ivr)                wiper_d = ivr;
    else if (ivr_we || wiper_we) wiper_d = wdata;
  end
  assign wiper_en = load_ivr | ivr_we | wiper_we;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      wiper_q <= W'(MID_CODE);
    else if (wiper_en) wiper_q <= wiper_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    vol_q <= 1'b0;
    else if (acr_we) vol_q <= wdata[W-1];
  end

  assign wiper = wiper_q;
endmodule

// File: rtl/dpot_regs_chk.sv
module dpot_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       vol,
  input logic       nv_clear,
  input logic [7:0] ivr,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic       wr_en,
  input logic [7:0] rdata,
  input logic [7:0] wiper
);
  p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> wiper == 8'h80);

  p_recall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> wiper == $past(ivr));

  p_lockout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_en && !nv_clear) |=> ($stable(ivr) && $stable(vol)));

  p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && !vol && !nv_clear && addr == 4'd0)
      |=> (wiper == $past(wdata) && ivr == $past(wdata)));

  p_volonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && vol && !nv_clear && addr == 4'd0)
      |=> (wiper == $past(wdata) && $stable(ivr)));

  p_acr_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 4'd8 |-> rdata == {vol, 7'b0});

  p_id_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd1 && !vol) |-> rdata == 8'h80);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd7 || addr > 4'd8) |-> rdata == 8'h00);
endmodule

bind dpot_regs dpot_regs_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .run(run), .vol(vol_q), .nv_clear(nv_clear),
  .ivr(ivr), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rdata(rdata), .wiper(wiper)
);

// File: tb/dpot_regs_bench.sv
`timescale 1ns/1ps
module dpot_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n, nv_clear, mem_ready, wr_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata, wiper;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dpot_regs u_dpot_regs (
    .clk(clk), .rst_n(rst_n), .nv_clear(nv_clear), .mem_ready(mem_ready),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata), .wiper(wiper)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] gpv [5];
    rst_n = 1'b0; nv_clear = 1'b1; mem_ready = 1'b0;
    wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); nv_clear = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 reset wiper", wiper, 8'h80);
    rd("R6 selector after reset", 4'd8, 8'h00);
    rd("R6 factory start-up value", 4'd0, 8'h80);
    for (int i = 0; i < 5; i++) rd("R6 factory gp", 4'(2 + i), 8'h00);

    // R10: writes before recall are ignored
    wr(4'd0, 8'h55);
    wr(4'd8, 8'h80);
    wr(4'd2, 8'h77);
    chk("R10 wiper locked", wiper, 8'h80);
    rd("R10 selector locked", 4'd8, 8'h00);
    rd("R10 start-up value locked", 4'd0, 8'h80);
    rd("R10 gp locked", 4'd2, 8'h00);

    // R2 recall
    @(negedge clk); mem_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 still mid before recall edge", wiper, 8'h80);
    @(posedge clk); @(negedge clk);
    chk("R2 recalled", wiper, 8'h80);

    // R12 edge timing
    @(negedge clk); addr = 4'd0; wdata = 8'h21; wr_en = 1'b1;
    #1 chk("R12 no change before edge", wiper, 8'h80);
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    chk("R12 change at edge", wiper, 8'h21);

    // R1 / R5: exhaustive sweep through the start-up value path
    for (int v = 0; v < 256; v++) begin
      wr(4'd0, 8'(v));
      chk("R1 wiper code", wiper, 8'(v));
      rd("R5 start-up value mirrored", 4'd0, 8'(v));
    end

    // R4 general-purpose bytes
    for (int i = 0; i < 5; i++) begin
      gpv[i] = 8'(8'h3A * (i + 1) + 7);
      wr(4'(2 + i), gpv[i]);
    end
    for (int i = 0; i < 5; i++) rd("R4 gp readback", 4'(2 + i), gpv[i]);

    // R8 identification byte
    rd("R8 id read", 4'd1, 8'h80);
    wr(4'd1, 8'h12);
    rd("R8 id write ignored", 4'd1, 8'h80);

    // R9 reserved addresses
    wr(4'd7, 8'hE7);
    rd("R9 addr 7", 4'd7, 8'h00);
    for (int a = 9; a < 16; a++) begin
      wr(4'(a), 8'hC3);
      rd("R9 high addr", 4'(a), 8'h00);
    end
    for (int i = 0; i < 5; i++) rd("R9 gp untouched", 4'(2 + i), gpv[i]);
    rd("R9 start-up value untouched", 4'd0, 8'hFF);
    chk("R9 wiper untouched", wiper, 8'hFF);

    // R7 / R3 / R4 with selector set
    wr(4'd8, 8'hFF);
    rd("R7 only bit 7 kept", 4'd8, 8'h80);
    wr(4'd0, 8'h3C);
    chk("R3 volatile write", wiper, 8'h3C);
    rd("R3 reads wiper", 4'd0, 8'h3C);
    for (int a = 1; a < 7; a++) rd("R4 hidden when selected", 4'(a), 8'h00);
    wr(4'd2, 8'hAA);
    wr(4'd8, 8'h7F);
    rd("R7 bit 7 cleared", 4'd8, 8'h00);
    rd("R3 start-up value kept", 4'd0, 8'hFF);
    rd("R4 gp write ignored when selected", 4'd2, gpv[0]);
    chk("R3 wiper kept after deselect", wiper, 8'h3C);

    // R11 / R2 / R6 power cycle with non-default stored value
    wr(4'd0, 8'h5A);
    wr(4'd8, 8'h80);
    @(negedge clk); rst_n = 1'b0; mem_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 mid after reset", wiper, 8'h80);
    rd("R6 selector cleared by reset", 4'd8, 8'h00);
    @(negedge clk); mem_ready = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 recall stored value", wiper, 8'h5A);
    rd("R11 start-up value retained", 4'd0, 8'h5A);
    for (int i = 0; i < 5; i++) rd("R11 gp retained", 4'(2 + i), gpv[i]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule